// File: doc/BRIEF.md
# Tuner Synthesizer Control Receiver

This block is a two-wire serial bus slave that takes setup data for a frequency synthesizer. A write carries two or four data bytes after the address byte. The top bit of the first byte in each pair tells the receiver where the pair goes. When that bit is 0, the pair forms a 15-bit divide ratio. When it is 1, the first byte is a control byte (test field, reference-select pair, oscillator bit) and the second byte is a band-switch byte. Each pair is written to the parallel outputs only after both of its bytes have been acknowledged. Both pair orders may appear in one four-byte write.

A read returns one status byte. The byte holds a power-on flag, a lock input and a three-bit code input. The power-on flag is set by reset and cleared once it has been reported in a read. Both bus lines are synchronized to the system clock, which must run at least eight times the SCL rate. The data line is driven in open-drain style: a single enable pulls it low.

Top module: `tuner_i2c_rx`

## Requirements
- R1: The slave answers only the address byte whose upper seven bits are 1,1,0,0,0 followed by `addr_sel[1]`, `addr_sel[0]`. Bit 0 of the address byte is 0 for a write and 1 for a read. For any other address it leaves SDA released during the 9th clock, and the rest of the transaction has no effect on the outputs.
- R2: During the 9th clock, the slave pulls SDA low to acknowledge a matching address and each of the first four data bytes. A fifth and any later data byte get no acknowledge and change nothing.
- R3: Bit 7 of data byte 1 and of data byte 3 selects the pair type: 0 means divider pair, 1 means control/band pair. Both pair orders work within one transaction.
- R4: A divider pair (first byte F, second byte S) sets `div_ratio` to {F[6:0], S[7:0]}.
- R5: A control/band pair (control byte C, band byte B) sets `test_mode`=C[5:3], `ref_sel`=C[2:1], `osc_ctrl`=C[0] and `band_sw`=B[3:0]. C[6] and B[7:4] are ignored.
- R6: Outputs change only after the second byte of a pair has been acknowledged. A pair cut short by STOP or by a repeated START leaves every output unchanged.
- R7: A read sends, MSB first, the status byte {por, `lock_i`, 0, 0, 0, `code_i[2:0]`}.
- R8: The power-on flag is 1 after reset, is reported in the next status read, and is 0 in every read after that one.
- R9: After reset, `div_ratio`, `test_mode`, `ref_sel`, `osc_ctrl` and `band_sw` are 0 and `sda_oe` is 0.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Low two bits of the slave address |
| lock_i | input | 1 | Synthesizer lock flag, reported in status |
| code_i | input | 3 | Three-bit code reported in status |
| div_ratio | output | 15 | Latched divide ratio |
| test_mode | output | 3 | Test field from the control byte |
| ref_sel | output | 2 | Reference-select pair from the control byte |
| osc_ctrl | output | 1 | Oscillator bit from the control byte |
| band_sw | output | 4 | Band-switch outputs |

## Verification
The bench covers these cases:
- A pair truncated by STOP after one byte. A design that latched each byte as it arrived would corrupt `div_ratio` here.
- A pair truncated by a repeated START. A design that kept a half pair across the restart would combine bytes from two transactions.
- A fifth data byte. A design that ran off the end of its byte count would acknowledge it or take it as a new pair.
- A foreign address, and a change of `addr_sel`. These show whether address matching uses the pins or is fixed.
- Two status reads in a row. A design that clears the power-on flag too early, or never clears it, shows up here.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 15;
    localparam int BAND_W   = 4;
    localparam int TEST_W   = 3;
    localparam int CODE_W   = 3;
    localparam int SEL_W    = 2;
    localparam int MAX_DATA = 4;
    localparam int IDX_W    = $clog2(MAX_DATA);
    localparam int CNT_W    = $clog2(MAX_DATA + 1);
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam logic [6-SEL_W:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_WAITF,
        ST_ACK,
        ST_TX,
        ST_SKIP
    } eng_state_e;

    typedef enum logic [1:0] {
        ACK_ADDR_W,
        ACK_ADDR_R,
        ACK_DATA
    } ack_kind_e;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic [1:0]        ref_sel;
        logic              osc;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } byte_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [SEL_W-1:0] sel);
        return b[BYTE_W-1:1] == {ADDR_FIXED, sel};
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.test    = b[5:3];
        c.ref_sel = b[2:1];
        c.osc     = b[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic por,
                                                      input logic lock,
                                                      input logic [CODE_W-1:0] code);
        return {por, lock, 3'b000, code};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import tuner_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_d;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '1;
            else     sh <= {sh[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = sh[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= '1;
        else     lvl_d <= lvl;
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~lvl_d[0];
    assign scl_fall  = ~lvl[0] & lvl_d[0];
    assign start_det = lvl[0] & lvl_d[0] & lvl_d[1] & ~lvl[1];
    assign stop_det  = lvl[0] & lvl_d[0] & ~lvl_d[1] & lvl[1];

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output byte_ev_t          byte_ev,
    output logic              tx_done
);

    eng_state_e        state;
    ack_kind_e         kind;
    logic              is_addr;
    logic [BIT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  data_cnt;
    logic [BYTE_W-1:0] sreg;
    logic [BYTE_W-1:0] txsh;

    always_ff @(posedge clk) begin
        byte_ev.valid <= 1'b0;
        tx_done       <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= ACK_ADDR_W;
            is_addr  <= 1'b0;
            bitcnt   <= '0;
            data_cnt <= '0;
            sreg     <= '0;
            txsh     <= '0;
            sda_oe   <= 1'b0;
            byte_ev  <= '0;
        end else if (start_det) begin
            state    <= ST_RX;
            is_addr  <= 1'b1;
            bitcnt   <= '0;
            data_cnt <= '0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: if (scl_rise) begin
                    sreg <= {sreg[BYTE_W-2:0], sda_lvl};
                    if (bitcnt == BIT_W'(BYTE_W - 1)) state <= ST_WAITF;
                    else                              bitcnt <= bitcnt + 1'b1;
                end
                ST_WAITF: if (scl_fall) begin
                    if (is_addr) begin
                        if (addr_hit(sreg, addr_sel)) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            kind   <= sreg[0] ? ACK_ADDR_R : ACK_ADDR_W;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end else if (data_cnt < CNT_W'(MAX_DATA)) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                        kind   <= ACK_DATA;
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    case (kind)
                        ACK_ADDR_R: begin
                            txsh   <= status_byte;
                            sda_oe <= ~status_byte[BYTE_W-1];
                            state  <= ST_TX;
                        end
                        ACK_DATA: begin
                            sda_oe        <= 1'b0;
                            byte_ev.valid <= 1'b1;
                            byte_ev.idx   <= data_cnt[IDX_W-1:0];
                            byte_ev.data  <= sreg;
                            data_cnt      <= data_cnt + 1'b1;
                            state         <= ST_RX;
                        end
                        default: begin
                            sda_oe  <= 1'b0;
                            is_addr <= 1'b0;
                            state   <= ST_RX;
                        end
                    endcase
                end
                ST_TX: if (scl_fall) begin
                    if (bitcnt == BIT_W'(BYTE_W - 1)) begin
                        sda_oe  <= 1'b0;
                        tx_done <= 1'b1;
                        state   <= ST_SKIP;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txsh[BYTE_W-2];
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);

    // R2
    ack_before_byte_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ev.valid |-> $past(sda_oe));

    // R7
    tx_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> !sda_oe);

endmodule

// File: rtl/pair_router.sv
module pair_router
    import tuner_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_clr,
    input  byte_ev_t          byte_ev,
    output logic [DIV_W-1:0]  div_q,
    output ctrl_t             ctrl_q,
    output logic [BAND_W-1:0] band_q
);

    logic [BYTE_W-1:0] held;
    logic              held_ok;
    logic              second;

    assign second = byte_ev.valid & byte_ev.idx[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            held_ok <= 1'b0;
            div_q   <= '0;
            ctrl_q  <= '0;
            band_q  <= '0;
        end else if (xfer_clr) begin
            held_ok <= 1'b0;
        end else if (byte_ev.valid) begin
            if (!byte_ev.idx[0]) begin
                held    <= byte_ev.data;
                held_ok <= 1'b1;
            end else if (held_ok) begin
                held_ok <= 1'b0;
                if (held[BYTE_W-1]) begin
                    ctrl_q <= decode_ctrl(held);
                    band_q <= byte_ev.data[BAND_W-1:0];
                end else begin
                    div_q <= {held[BYTE_W-2:0], byte_ev.data};
                end
            end
        end
    end

    // R6
    div_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> $past(second));

    // R5
    band_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_q) |-> $past(second));

endmodule

// File: rtl/tuner_i2c_rx.sv
module tuner_i2c_rx
    import tuner_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic              lock_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [TEST_W-1:0] test_mode,
    output logic [1:0]        ref_sel,
    output logic              osc_ctrl,
    output logic [BAND_W-1:0] band_sw
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic tx_done;
    logic por_q;
    logic [BYTE_W-1:0] status_byte;
    byte_ev_t byte_ev;
    ctrl_t    ctrl_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign status_byte = pack_status(por_q, lock_i, code_i);

    i2c_bit_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .addr_sel    (addr_sel),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .byte_ev     (byte_ev),
        .tx_done     (tx_done)
    );

    pair_router u_route (
        .clk      (clk),
        .rst      (rst),
        .xfer_clr (start_det | stop_det),
        .byte_ev  (byte_ev),
        .div_q    (div_ratio),
        .ctrl_q   (ctrl_q),
        .band_q   (band_sw)
    );

    always_ff @(posedge clk) begin
        if (rst)          por_q <= 1'b1;
        else if (tx_done) por_q <= 1'b0;
    end

    assign test_mode = ctrl_q.test;
    assign ref_sel   = ctrl_q.ref_sel;
    assign osc_ctrl  = ctrl_q.osc;

    // R8
    por_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(por_q) |-> $past(tx_done));

    // R8
    por_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(por_q));

endmodule

// File: tb/tuner_i2c_rx_test.sv
module tuner_i2c_rx_test;

    localparam int H = 10;

    typedef struct packed {
        logic [2:0]  n;
        logic [31:0] bytes;
        logic [14:0] div;
        logic [5:0]  ctl;
        logic [3:0]  band;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 32'hAD0B_0000, 15'h0000, 6'h2D, 4'hB},
        '{3'd2, 32'h1234_0000, 15'h1234, 6'h2D, 4'hB},
        '{3'd4, 32'hC2F5_7FFF, 15'h7FFF, 6'h02, 4'h5},
        '{3'd4, 32'h0001_FF0F, 15'h0001, 6'h3F, 4'hF},
        '{3'd2, 32'h55AA_0000, 15'h55AA, 6'h3F, 4'hF},
        '{3'd2, 32'h8000_0000, 15'h55AA, 6'h00, 4'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic lock_i = 1'b0;
    logic [2:0] code_i = 3'b000;
    logic sda_oe;
    logic [14:0] div_ratio;
    logic [2:0] test_mode;
    logic [1:0] ref_sel;
    logic osc_ctrl;
    logic [3:0] band_sw;
    logic sda_line;

    int vectors = 0;
    int miscompares = 0;
    int oe_viol = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    tuner_i2c_rx uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .lock_i    (lock_i),
        .code_i    (code_i),
        .div_ratio (div_ratio),
        .test_mode (test_mode),
        .ref_sel   (ref_sel),
        .osc_ctrl  (osc_ctrl),
        .band_sw   (band_sw)
    );

    // R10 monitor: sda_oe must not move while SCL is high
    logic last_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe !== last_oe && scl_m) oe_viol++;
        last_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ctl_now();
        return {test_mode, ref_sel, osc_ctrl};
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        ack = sda_line;
        tick(H / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic get_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H / 2);
            b[i] = sda_line;
            tick(H / 2);
            scl_m = 1'b0; tick(2);
        end
        tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    // acks[0] = address ack, acks[k] = data byte k ack (0 = acknowledged)
    task automatic wr(input logic [7:0] a, input int n, input logic [39:0] data,
                      input bit stop, output logic [5:0] acks);
        logic ak;
        acks = '1;
        bus_start();
        put_byte(a, ak); acks[0] = ak;
        for (int k = 0; k < n; k++) begin
            put_byte(data[39 - 8*k -: 8], ak);
            acks[k + 1] = ak;
        end
        if (stop) bus_stop();
        tick(4);
    endtask

    task automatic rd(input logic [7:0] a, output logic ack, output logic [7:0] b);
        bus_start();
        put_byte(a, ack);
        get_byte(b);
        bus_stop();
        tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [5:0] acks;
        logic ak;
        logic [7:0] sb;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R9 reset state
        check("R9 div", 32'(div_ratio), 32'h0);
        check("R9 ctl", 32'(ctl_now()), 32'h0);
        check("R9 band", 32'(band_sw), 32'h0);
        check("R9 sda_oe", 32'(sda_oe), 32'h0);

        // R7 R8 status reads: first shows power-on flag, second does not
        lock_i = 1'b1; code_i = 3'b101;
        rd(8'hC5, ak, sb);
        check("R1 read addr ack", 32'(ak), 32'h0);
        check("R8 first status", 32'(sb), 32'hC5);
        rd(8'hC5, ak, sb);
        check("R8 second status", 32'(sb), 32'h45);
        lock_i = 1'b0; code_i = 3'b010;
        rd(8'hC5, ak, sb);
        check("R7 status fields", 32'(sb), 32'h02);

        // R3 R4 R5 vector table
        for (int v = 0; v < NV; v++) begin
            wr(8'hC4, int'(VECS[v].n), {VECS[v].bytes, 8'h00}, 1'b1, acks);
            for (int k = 0; k <= int'(VECS[v].n); k++)
                check("R2 ack", 32'(acks[k]), 32'h0);
            check("R4 div", 32'(div_ratio), 32'(VECS[v].div));
            check("R5 ctl", 32'(ctl_now()), 32'(VECS[v].ctl));
            check("R3 band", 32'(band_sw), 32'(VECS[v].band));
        end

        // R1 foreign address
        wr(8'hC0, 2, 40'h1234_0000_00, 1'b1, acks);
        check("R1 foreign nack", 32'(acks[0]), 32'h1);
        check("R1 foreign no effect", 32'(div_ratio), 32'h55AA);

        // R6 pair cut by stop
        wr(8'hC4, 1, 40'h0100_0000_00, 1'b1, acks);
        check("R6 truncated div", 32'(div_ratio), 32'h55AA);

        // R6 three bytes: first pair applies, half pair dropped
        wr(8'hC4, 3, 40'h9C03_2200_00, 1'b1, acks);
        check("R6 three-byte ctl", 32'(ctl_now()), 32'h1C);
        check("R6 three-byte band", 32'(band_sw), 32'h3);
        check("R6 three-byte div", 32'(div_ratio), 32'h55AA);

        // R2 fifth byte ignored
        wr(8'hC4, 5, 40'h1122_A106_77, 1'b1, acks);
        check("R2 fifth nack", 32'(acks[5]), 32'h1);
        check("R2 four acks", 32'(acks[4:0]), 32'h0);
        check("R2 div", 32'(div_ratio), 32'h1122);
        check("R2 ctl", 32'(ctl_now()), 32'h21);
        check("R2 band", 32'(band_sw), 32'h6);

        // R6 repeated start drops the half pair
        wr(8'hC4, 1, 40'h8F00_0000_00, 1'b0, acks);
        wr(8'hC4, 2, 40'h0005_0000_00, 1'b1, acks);
        check("R6 rep-start ctl", 32'(ctl_now()), 32'h21);
        check("R6 rep-start band", 32'(band_sw), 32'h6);
        check("R6 rep-start div", 32'(div_ratio), 32'h0005);

        // R1 address select pins
        addr_sel = 2'b01;
        wr(8'hC4, 2, 40'h0007_0000_00, 1'b1, acks);
        check("R1 old addr nack", 32'(acks[0]), 32'h1);
        check("R1 old addr no effect", 32'(div_ratio), 32'h0005);
        wr(8'hC2, 2, 40'h0009_0000_00, 1'b1, acks);
        check("R1 new addr ack", 32'(acks[0]), 32'h0);
        check("R1 new addr div", 32'(div_ratio), 32'h0009);

        check("R10 oe changes with SCL high", 32'(oe_viol), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule